// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus whose data line is held low by a target device, the typical result of a read cut off partway through a byte. When asked to start, it takes both open-drain lines away from the normal controller. It clocks SCL until the target lets SDA float high, which happens on a data one-bit or in the acknowledge slot. It then forms a STOP condition and returns both lines.

SCL and SDA are controlled only through pull-low enables: a line is either pulled to ground or released. The block reads SDA back through a two-flop synchronizer and samples it at the end of every SCL-low half period. The half period is set in system clock cycles. The default of 625 cycles at 125 MHz gives 5 µs, which is standard-mode 100 kHz timing. At most `MAX_PULSES` clock pulses are issued, 9 by default: eight data bits and the acknowledge slot. If SDA is still low after the last one, a failure flag is raised and the STOP is attempted anyway.

Top module: `i2c_recover_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, and after it is released with no start, `busy_o`, `done_o`, `fail_o`, `scl_pull_o` and `sda_pull_o` are all 0.
- R2: A start seen while idle makes `busy_o` 1 on the next cycle. `scl_pull_o` is then 1 and `sda_pull_o` is 0 for exactly `HALF_CYC` cycles before the first SDA sample.
- R3: SDA is sampled through a two-flop synchronizer at the end of every SCL-low half period. If the sampled level is high, no further pulse is issued. This means zero pulses when SDA is already high at the first sample.
- R4: Each pulse releases SCL (`scl_pull_o`=0) for `HALF_CYC` cycles and then pulls it (`scl_pull_o`=1) for `HALF_CYC` cycles.
- R5: No more than `MAX_PULSES` pulses are issued in one recovery. After the last one, the block moves to the STOP phase whatever the SDA level.
- R6: The STOP phase has three steps of `HALF_CYC` cycles each:
  - both lines pulled;
  - SCL released with SDA still pulled;
  - both released.
  The release of SDA therefore happens only while SCL is released.
- R7: `busy_o` stays 1 from the cycle after the start until the last STOP step ends. A start that arrives while busy has no effect on the sequence.
- R8: `done_o` is a single-cycle pulse in the cycle after the final step ends. In that cycle `busy_o`, `scl_pull_o` and `sda_pull_o` are 0.
- R9: `fail_o` becomes 1 when the sample after the last allowed pulse still reads SDA low. It stays at its value until the next accepted start, which clears it.
- R10: `sda_pull_o` is 0 throughout the lead-in and pulsing phases. It is 1 only in the first two STOP steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin a recovery; only acted on while idle |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | SDA was still low after the last permitted pulse |
| scl_pull_o | output | 1 | Pull SCL low (open-drain enable) |
| sda_pull_o | output | 1 | Pull SDA low (open-drain enable) |
| scl_i | input | 1 | Sampled SCL level (observed only, no stretching handled) |
| sda_i | input | 1 | Sampled SDA level, synchronized inside |

## Verification
The properties assume the bus has no clock stretching and no other controller: SCL is taken to follow the block's own pull enable, and the only other force on SDA is a target that holds it low. The properties also assume that `HALF_CYC` is at least a few cycles, so that a level change reaches the synchronizer output before the next sample. The bench models the target as a device that releases SDA on a chosen SCL rising edge, or never. It wires SCL as the plain inverse of the pull enable and runs with `HALF_CYC` = 8. This keeps every SDA change more than two cycles ahead of the sample that must see it.

// File: rtl/i2c_recover_pkg.sv
package i2c_recover_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SCL_HI,
        ST_SCL_LO,
        ST_STP_SET,
        ST_STP_RISE,
        ST_STP_HOLD
    } rcv_state_e;

endpackage

// File: rtl/rcv_sync2.sv
module rcv_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/rcv_half_timer.sv
module rcv_half_timer #(
    parameter int HALF_CYC = 625
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic expire_o
);
    localparam int CW = $clog2(HALF_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expire_o = (cnt_q == LAST);
endmodule

// File: rtl/i2c_recover_seq.sv
module i2c_recover_seq
    import i2c_recover_pkg::*;
#(
    parameter int HALF_CYC   = 625,
    parameter int MAX_PULSES = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o,
    output logic done_o,
    output logic fail_o,
    output logic scl_pull_o,
    output logic sda_pull_o,
    input  logic scl_i,
    input  logic sda_i
);
    localparam int PW = $clog2(MAX_PULSES + 1);
    localparam logic [PW-1:0] PULSE_LIMIT = PW'(MAX_PULSES);

    typedef struct packed {
        rcv_state_e    state;
        logic [PW-1:0] pulses;
        logic          fail;
        logic          done;
        logic          scl_pull;
        logic          sda_pull;
    } rcv_regs_t;

    rcv_regs_t r_d, r_q;
    logic sda_s;
    logic tmr_clr;
    logic tmr_exp;
    logic scl_unused;

    // SCL is only observed; no stretching support
    assign scl_unused = scl_i;

    rcv_sync2 #(.RST_VAL(1'b1)) u_sda_sync (
        .clk (clk),
        .rst (rst),
        .d_i (sda_i),
        .q_o (sda_s)
    );

    rcv_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (tmr_clr),
        .expire_o (tmr_exp)
    );

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        tmr_clr = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                tmr_clr = 1'b1;
                if (start_i) begin
                    r_d.state  = ST_LEAD;
                    r_d.pulses = '0;
                    r_d.fail   = 1'b0;
                end
            end
            ST_LEAD, ST_SCL_LO: begin
                if (tmr_exp) begin
                    tmr_clr = 1'b1;
                    if (sda_s || r_q.pulses == PULSE_LIMIT) begin
                        r_d.state = ST_STP_SET;
                        r_d.fail  = ~sda_s;
                    end else begin
                        r_d.state  = ST_SCL_HI;
                        r_d.pulses = r_q.pulses + 1'b1;
                    end
                end
            end
            ST_SCL_HI: begin
                if (tmr_exp) begin
                    tmr_clr   = 1'b1;
                    r_d.state = ST_SCL_LO;
                end
            end
            ST_STP_SET: begin
                if (tmr_exp) begin
                    tmr_clr   = 1'b1;
                    r_d.state = ST_STP_RISE;
                end
            end
            ST_STP_RISE: begin
                if (tmr_exp) begin
                    tmr_clr   = 1'b1;
                    r_d.state = ST_STP_HOLD;
                end
            end
            ST_STP_HOLD: begin
                if (tmr_exp) begin
                    tmr_clr   = 1'b1;
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: begin
                tmr_clr   = 1'b1;
                r_d.state = ST_IDLE;
            end
        endcase

        // line enables registered alongside the state they belong to
        r_d.scl_pull = (r_d.state == ST_LEAD) || (r_d.state == ST_SCL_LO) ||
                       (r_d.state == ST_STP_SET);
        r_d.sda_pull = (r_d.state == ST_STP_SET) || (r_d.state == ST_STP_RISE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state    <= ST_IDLE;
            r_q.pulses   <= '0;
            r_q.fail     <= 1'b0;
            r_q.done     <= 1'b0;
            r_q.scl_pull <= 1'b0;
            r_q.sda_pull <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o     = (r_q.state != ST_IDLE);
    assign done_o     = r_q.done;
    assign fail_o     = r_q.fail;
    assign scl_pull_o = r_q.scl_pull;
    assign sda_pull_o = r_q.sda_pull;
endmodule

// File: rtl/i2c_recover_chk.sv
module i2c_recover_chk #(
    parameter int MAX_PULSES = 9
) (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic fail_o,
    input logic scl_pull_o,
    input logic sda_pull_o
);
    int   rel_cnt;
    logic scl_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            rel_cnt  <= 0;
            scl_prev <= 1'b0;
        end else begin
            scl_prev <= scl_pull_o;
            if (!busy_o)
                rel_cnt <= 0;
            else if (scl_prev && !scl_pull_o)
                rel_cnt <= rel_cnt + 1;
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!scl_pull_o && !sda_pull_o)); // R1

    AST_LEAD_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (scl_pull_o && !sda_pull_o)); // R2

    AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        rel_cnt <= MAX_PULSES + 1); // R5

    AST_SDA_RISE_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_pull_o) |-> !scl_pull_o); // R6

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && !scl_pull_o && !sda_pull_o)); // R8

    AST_FAIL_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(fail_o)); // R9

    AST_SDA_ONLY_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> scl_pull_o); // R10
endmodule

bind i2c_recover_seq i2c_recover_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fail_o     (fail_o),
    .scl_pull_o (scl_pull_o),
    .sda_pull_o (sda_pull_o)
);

// File: tb/i2c_recover_seq_tb.sv
`timescale 1ns/1ps
module i2c_recover_seq_tb;
    localparam int HALF = 8;
    localparam int MAXP = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done, fail, scl_pull, sda_pull;
    logic scl_line, sda_line;

    // target model
    int   rise_cnt = 0;
    int   tgt_base = 0;
    int   tgt_rel  = 0;
    logic tgt_hold = 1'b0;
    logic tgt_low;
    int   stop_cnt = 0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic wd_hit = 1'b0;

    always #4 clk = ~clk;

    assign scl_line = ~scl_pull;
    assign tgt_low  = tgt_hold && ((rise_cnt - tgt_base) < tgt_rel);
    assign sda_line = ~(sda_pull | tgt_low);

    always @(posedge scl_line) rise_cnt = rise_cnt + 1;
    always @(negedge sda_pull) if (scl_line) stop_cnt = stop_cnt + 1;

    i2c_recover_seq #(.HALF_CYC(HALF), .MAX_PULSES(MAXP)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .busy_o     (busy),
        .done_o     (done),
        .fail_o     (fail),
        .scl_pull_o (scl_pull),
        .sda_pull_o (sda_pull),
        .scl_i      (scl_line),
        .sda_i      (sda_line)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // behavioural reference: phase 0 idle,1 lead,2 scl high,3 scl low,4..6 stop steps
    int   m_phase = 0, m_t = 0, m_n = 0;
    logic m_fail = 1'b0, m_done = 1'b0;
    logic hist[$];
    logic started = 1'b0;

    task automatic model_step();
        logic seen;
        seen = hist[0];
        void'(hist.pop_front());
        hist.push_back(sda_line);
        m_done = 1'b0;
        if (rst) begin
            m_phase = 0; m_t = 0; m_n = 0; m_fail = 1'b0;
            hist = '{1'b1, 1'b1};
        end else if (m_phase == 0) begin
            m_t = 0;
            if (start) begin m_phase = 1; m_n = 0; m_fail = 1'b0; end
        end else if (m_t < HALF - 1) begin
            m_t++;
        end else begin
            m_t = 0;
            if (m_phase == 1 || m_phase == 3) begin
                if (seen || m_n == MAXP) begin
                    m_fail  = !seen;
                    m_phase = 4;
                end else begin
                    m_n++;
                    m_phase = 2;
                end
            end else if (m_phase == 2) m_phase = 3;
            else if (m_phase == 6) begin m_phase = 0; m_done = 1'b1; end
            else m_phase = m_phase + 1;
        end
    endtask

    initial begin
        hist = '{1'b1, 1'b1};
        forever begin
            @(negedge clk);
            #1;
            cyc++;
            if (started) begin
                logic e_scl, e_sda;
                e_scl = (m_phase == 1 || m_phase == 3 || m_phase == 4);
                e_sda = (m_phase == 4 || m_phase == 5);
                chk(scl_pull == e_scl, "R2 R4 scl_pull", scl_pull, e_scl);
                chk(sda_pull == e_sda, "R6 R10 sda_pull", sda_pull, e_sda);
                chk(busy == (m_phase != 0), "R7 busy", busy, m_phase != 0);
                chk(done == m_done, "R8 done", done, m_done);
                chk(fail == m_fail, "R9 fail", fail, m_fail);
            end
            model_step();
            started = 1'b1;
            if (cyc > 100000 && !wd_hit) begin
                wd_hit = 1'b1;
                chk(1'b0, "watchdog", cyc, 100000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    task automatic recover(input int rel, input logic hold, input int exp_pulses,
                           input logic exp_fail, input logic poke_busy);
        int base_rise, base_stop, wait_n;
        @(negedge clk);
        tgt_hold = hold;
        tgt_rel  = rel;
        tgt_base = rise_cnt;
        base_rise = rise_cnt;
        base_stop = stop_cnt;
        start <= 1'b1;
        @(negedge clk);
        start <= 1'b0;
        if (poke_busy) begin
            repeat (3 * HALF + 2) @(negedge clk);
            start <= 1'b1;
            @(negedge clk);
            start <= 1'b0;
        end
        wait_n = 0;
        while (!done && wait_n < 2000) begin
            @(negedge clk);
            #2;
            wait_n++;
        end
        chk(wait_n < 2000, "R8 done seen", wait_n, 2000);
        // SCL rises: one per pulse plus the STOP release
        chk((rise_cnt - base_rise) == exp_pulses + 1, "R3 R5 pulse count",
            rise_cnt - base_rise - 1, exp_pulses);
        chk((stop_cnt - base_stop) == 1, "R6 stop edge", stop_cnt - base_stop, 1);
        chk(fail == exp_fail, "R9 fail after run", fail, exp_fail);
        tgt_hold = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk(!busy && !done && !fail && !scl_pull && !sda_pull, "R1 in reset",
            {busy, done, fail, scl_pull, sda_pull}, 0);
        rst <= 1'b0;
        repeat (4) @(negedge clk);
        #2;
        chk(!busy && !scl_pull && !sda_pull, "R1 idle after reset",
            {busy, scl_pull, sda_pull}, 0);

        recover(0, 1'b0, 0, 1'b0, 1'b0);   // SDA already high: R3 zero pulses
        recover(3, 1'b1, 3, 1'b0, 1'b0);   // released on third rise
        recover(9, 1'b1, 9, 1'b0, 1'b0);   // released in acknowledge slot
        recover(100, 1'b1, 9, 1'b1, 1'b0); // never released: R5 R9
        recover(1, 1'b1, 1, 1'b0, 1'b0);   // R9 cleared by new start
        recover(5, 1'b1, 5, 1'b0, 1'b1);   // R7 start while busy ignored

        // reset in the middle of a run
        @(negedge clk);
        tgt_hold = 1'b1; tgt_rel = 100; tgt_base = rise_cnt;
        start <= 1'b1;
        @(negedge clk);
        start <= 1'b0;
        repeat (5 * HALF) @(negedge clk);
        rst <= 1'b1;
        repeat (2) @(negedge clk);
        #2;
        chk(!busy && !scl_pull && !sda_pull && !fail, "R1 reset mid run",
            {busy, scl_pull, sda_pull, fail}, 0);
        rst <= 1'b0;
        tgt_hold = 1'b0;
        repeat (3) @(negedge clk);
        recover(2, 1'b1, 2, 1'b0, 1'b0);

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule